// File: doc/BRIEF.md
# Live Register State Migration Controller

This block moves the state of a running register from an active copy (the original) to a spare copy (the replica) without pausing the user logic that updates it. Both copies see the same user data input and the same user clock enable. A host walks the migration forward one phase at a time with a step strobe, and can cancel it with an abort strobe. It watches the phase number, a sticky disagreement flag and a completion flag.

During the transfer phase a 2:1 selector picks the replica's next value. When the user enable is low, the selector passes the original's stored value. When the enable is high, it passes the live next-state value that the original is also loading. A user update that lands in the middle of the transfer therefore reaches both copies on the same edge. After the transfer the replica follows the user enable on its own. Both copies then run side by side for at least one cycle before the output switches to the replica.

A parameter selects the enable-gated form, which has nine phases, or the free-running form, which loads every cycle and has four phases.

Top module: `regmig_ctrl`

## Requirements
- R1: After a synchronous reset the phase is 0, the bypass select and capture control are low, the disagreement and completion flags are low, and the output is 0.
- R2: In the gated form the phase codes run 0 idle, 1 arm, 2 link, 3 capture, 4 unlink, 5 tie, 6 detach, 7 parallel, 8 released. Each step strobe moves the phase up by exactly one. A step strobe in phase 8 has no effect.
- R3: In the free-running form, step strobes walk the phase codes 0, 1, 7, 8 in that order.
- R4: In the gated form, bypass select is high in phases 2 and 3 only, and capture control is high in phase 3 only. In the free-running form both stay low.
- R5: On each edge in phase 3 the replica loads the original's stored value if the user enable is low, or the user data if it is high. On that same edge the original also loads the user data when the enable is high.
- R6: In phases 0 to 2 the replica holds its value. From phase 4 on it loads the user data only on edges where the user enable is high.
- R7: The output shows the original's value in phases 0 to 7. It shows the replica's value from the edge that enters phase 8.
- R8: The disagreement flag sets when the two copies differ in phase 7. It stays set until a step strobe without abort is taken in phase 0. With coherent copies it stays low.
- R9: An abort strobe in phases 0 to 7 returns the phase to 0 on the next edge, taking bypass select and capture control low and giving the output back to the original. Abort wins over a simultaneous step. In phase 8 an abort has no effect.
- R10: In the free-running form the user enable is ignored, and the copies that are loading take the user data on every edge.
- R11: The completion flag is high exactly while the phase is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| user_ce | input | 1 | User clock enable shared by both copies |
| user_d | input | W | User next-state value |
| user_q | output | W | Register value seen by the user circuit |
| host_step | input | 1 | Advance the migration by one phase |
| host_abort | input | 1 | Cancel the migration and return to the original |
| stat_step | output | 4 | Current phase code |
| stat_mismatch | output | 1 | Sticky copy disagreement flag |
| stat_released | output | 1 | Migration complete; replica drives output |
| byp_sel | output | 1 | Transfer path into the replica connected |
| cap_ctl | output | 1 | Replica forced to load the selector |

## Verification
The delicate coincidence is a user enable pulse on the same edge where capture control forces the replica to load. In that case the selector must hand over the live next-state value, not the stale stored one. The bench holds the capture phase for several cycles with the enable high, then low, then high on the edge that leaves the phase. Its reference model predicts the later released output from the data last loaded. The second coincidence is an abort and a step strobe in the same cycle, which must land in phase 0.

// File: rtl/regmig_pkg.sv
package regmig_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_ARM      = 4'd1,
    ST_LINK     = 4'd2,
    ST_CAPTURE  = 4'd3,
    ST_UNLINK   = 4'd4,
    ST_TIE      = 4'd5,
    ST_DETACH   = 4'd6,
    ST_PARALLEL = 4'd7,
    ST_RELEASED = 4'd8
  } mig_step_e;

  // Successor phase; the free-running form skips the transfer phases.
  function automatic mig_step_e next_step(mig_step_e cur, logic gated);
    mig_step_e nx;
    case (cur)
      ST_IDLE:     nx = ST_ARM;
      ST_ARM:      nx = gated ? ST_LINK : ST_PARALLEL;
      ST_LINK:     nx = ST_CAPTURE;
      ST_CAPTURE:  nx = ST_UNLINK;
      ST_UNLINK:   nx = ST_TIE;
      ST_TIE:      nx = ST_DETACH;
      ST_DETACH:   nx = ST_PARALLEL;
      ST_PARALLEL: nx = ST_RELEASED;
      default:     nx = ST_RELEASED;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/regmig_seq.sv
module regmig_seq
  import regmig_pkg::*;
#(
  parameter bit GATED = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      step_req,
  input  logic      abort_req,
  output mig_step_e step_q,
  output logic      byp_sel,
  output logic      cap_ctl,
  output logic      rep_tie
);

  logic done;
  assign done = (step_q == ST_RELEASED);

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= ST_IDLE;
    else if (!done && abort_req)
      step_q <= ST_IDLE;
    else if (!done && step_req)
      step_q <= next_step(step_q, GATED);
  end

  always_comb begin
    byp_sel = GATED && (step_q == ST_LINK || step_q == ST_CAPTURE);
    cap_ctl = GATED && (step_q == ST_CAPTURE);
    if (GATED)
      rep_tie = (step_q >= ST_UNLINK);
    else
      rep_tie = (step_q >= ST_ARM);
  end

  // R4: the replica is never forced to load without the transfer path
  a_r4_cc_needs_byp: assert property (@(posedge clk) disable iff (rst)
    cap_ctl |-> byp_sel);

  // R9: abort before release lands in idle
  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (rst)
    (abort_req && step_q != ST_RELEASED) |=> step_q == ST_IDLE);

  // R2: the released phase is terminal
  a_r2_release_holds: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_RELEASED) |=> step_q == ST_RELEASED);

  // R2: a step strobe without abort always moves the phase
  a_r2_step_moves: assert property (@(posedge clk) disable iff (rst)
    (step_req && !abort_req && step_q != ST_RELEASED) |=> step_q != $past(step_q));

  generate
    if (!GATED) begin : g_free
      // R3: free-running form jumps from arm straight to parallel
      a_r3_skip_transfer: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_ARM && step_req && !abort_req) |=> step_q == ST_PARALLEL);
    end
  endgenerate

endmodule

// File: rtl/regmig_bank.sv
module regmig_bank #(
  parameter int  W     = 8,
  parameter bit  GATED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         user_ce,
  input  logic [W-1:0] user_d,
  input  logic         byp_sel,
  input  logic         cap_ctl,
  input  logic         rep_tie,
  output logic [W-1:0] orig_q,
  output logic [W-1:0] rep_q
);

  localparam bit FREE_RUN = !GATED;

  logic         ce_eff;
  logic [W-1:0] xfer_src;
  logic [W-1:0] rep_din;
  logic         rep_ld;

  assign ce_eff   = user_ce | FREE_RUN;
  // selector driven by the user enable: stored state or live next state
  assign xfer_src = ce_eff ? user_d : orig_q;
  assign rep_din  = byp_sel ? xfer_src : user_d;
  assign rep_ld   = cap_ctl | (rep_tie & ce_eff);

  always_ff @(posedge clk) begin
    if (rst)
      orig_q <= '0;
    else if (ce_eff)
      orig_q <= user_d;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rep_q <= '0;
    else if (rep_ld)
      rep_q <= rep_din;
  end

  // R5: after any capture edge both copies hold the same value
  a_r5_capture_coherent: assert property (@(posedge clk) disable iff (rst)
    cap_ctl |=> rep_q == orig_q);

  // R6: replica untouched while neither forced nor tied
  a_r6_replica_holds: assert property (@(posedge clk) disable iff (rst)
    (!cap_ctl && !rep_tie) |=> $stable(rep_q));

  // R10: free-running original follows the data every cycle
  a_r10_free_loads: assert property (@(posedge clk) disable iff (rst)
    FREE_RUN |=> orig_q == $past(user_d));

endmodule

// File: rtl/regmig_watch.sv
module regmig_watch
  import regmig_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mig_step_e    step_q,
  input  logic         step_req,
  input  logic         abort_req,
  input  logic [W-1:0] orig_q,
  input  logic [W-1:0] rep_q,
  output logic [W-1:0] out_q,
  output logic         mismatch,
  output logic         released
);

  logic restart;
  assign restart  = (step_q == ST_IDLE) && step_req && !abort_req;
  assign released = (step_q == ST_RELEASED);
  assign out_q    = released ? rep_q : orig_q;

  always_ff @(posedge clk) begin
    if (rst)
      mismatch <= 1'b0;
    else if (restart)
      mismatch <= 1'b0;
    else if (step_q == ST_PARALLEL && orig_q != rep_q)
      mismatch <= 1'b1;
  end

  // R7: copies agree whenever both drive in parallel
  a_r7_parallel_agree: assert property (@(posedge clk) disable iff (rst)
    (step_q == ST_PARALLEL) |-> orig_q == rep_q);

  // R8: disagreement flag is sticky until a restart
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !restart) |=> mismatch);

endmodule

// File: rtl/regmig_ctrl.sv
module regmig_ctrl
  import regmig_pkg::*;
#(
  parameter int W     = 8,
  parameter bit GATED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         user_ce,
  input  logic [W-1:0] user_d,
  output logic [W-1:0] user_q,
  input  logic         host_step,
  input  logic         host_abort,
  output logic [3:0]   stat_step,
  output logic         stat_mismatch,
  output logic         stat_released,
  output logic         byp_sel,
  output logic         cap_ctl
);

  mig_step_e    step_q;
  logic         rep_tie;
  logic [W-1:0] orig_q;
  logic [W-1:0] rep_q;

  regmig_seq #(.GATED(GATED)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .step_req  (host_step),
    .abort_req (host_abort),
    .step_q    (step_q),
    .byp_sel   (byp_sel),
    .cap_ctl   (cap_ctl),
    .rep_tie   (rep_tie)
  );

  regmig_bank #(.W(W), .GATED(GATED)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .user_ce (user_ce),
    .user_d  (user_d),
    .byp_sel (byp_sel),
    .cap_ctl (cap_ctl),
    .rep_tie (rep_tie),
    .orig_q  (orig_q),
    .rep_q   (rep_q)
  );

  regmig_watch #(.W(W)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .step_q    (step_q),
    .step_req  (host_step),
    .abort_req (host_abort),
    .orig_q    (orig_q),
    .rep_q     (rep_q),
    .out_q     (user_q),
    .mismatch  (stat_mismatch),
    .released  (stat_released)
  );

  assign stat_step = step_q;

  // R11: output ownership changes only together with the completion flag
  a_r11_handover: assert property (@(posedge clk) disable iff (rst)
    (!stat_released && $past(!stat_released)) |-> user_q == orig_q);

endmodule

// File: tb/regmig_ctrl_bench.sv
module regmig_ctrl_bench;

  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic [W-1:0] d = '0;
  logic st = 1'b0;
  logic ab = 1'b0;

  logic [W-1:0] q_g, q_f;
  logic [3:0] s_g, s_f;
  logic mm_g, mm_f, rel_g, rel_f, byp_g, byp_f, cc_g, cc_f;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmig_ctrl #(.W(W), .GATED(1'b1)) u_regmig_ctrl (
    .clk(clk), .rst(rst), .user_ce(ce), .user_d(d), .user_q(q_g),
    .host_step(st), .host_abort(ab), .stat_step(s_g),
    .stat_mismatch(mm_g), .stat_released(rel_g), .byp_sel(byp_g), .cap_ctl(cc_g)
  );

  regmig_ctrl #(.W(W), .GATED(1'b0)) u_free (
    .clk(clk), .rst(rst), .user_ce(ce), .user_d(d), .user_q(q_f),
    .host_step(st), .host_abort(ab), .stat_step(s_f),
    .stat_mismatch(mm_f), .stat_released(rel_f), .byp_sel(byp_f), .cap_ctl(cc_f)
  );

  typedef struct {
    logic [3:0]   s;
    logic [W-1:0] o;
    logic [W-1:0] r;
    logic         mm;
  } mdl_t;

  typedef struct {
    string tag;
    mdl_t  g;
    mdl_t  f;
  } exp_t;

  mdl_t mg, mf;
  exp_t sb[$];

  function automatic mdl_t nxt(mdl_t m, bit gated, bit c, logic [W-1:0] dv, bit stp, bit abt);
    mdl_t n = m;
    bit ce_e = gated ? c : 1'b1;
    if (ce_e) n.o = dv;
    if (gated && m.s == 4'd3) n.r = ce_e ? dv : m.o;
    else if ((gated ? (m.s >= 4'd4) : (m.s >= 4'd1)) && ce_e) n.r = dv;
    if (m.s == 4'd0 && stp && !abt) n.mm = 1'b0;
    else if (m.s == 4'd7 && m.o != m.r) n.mm = 1'b1;
    if (m.s != 4'd8) begin
      if (abt) n.s = 4'd0;
      else if (stp) begin
        if (gated) n.s = m.s + 4'd1;
        else n.s = (m.s == 4'd0) ? 4'd1 : (m.s == 4'd1) ? 4'd7 : 4'd8;
      end
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drv(string tag, bit c, logic [W-1:0] dv, bit stp, bit abt);
    exp_t e;
    @(negedge clk);
    ce = c; d = dv; st = stp; ab = abt;
    mg = nxt(mg, 1'b1, c, dv, stp, abt);
    mf = nxt(mf, 1'b0, c, dv, stp, abt);
    e.tag = tag; e.g = mg; e.f = mf;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce = 1'b0; d = '0; st = 1'b0; ab = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mg = '{s: 4'd0, o: '0, r: '0, mm: 1'b0};
    mf = '{s: 4'd0, o: '0, r: '0, mm: 1'b0};
  endtask

  // monitor: compares each edge's result against the queued prediction
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "step(R2)",  32'(s_g),   32'(e.g.s));
      chk(e.tag, "q(R7)",     32'(q_g),   32'((e.g.s == 4'd8) ? e.g.r : e.g.o));
      chk(e.tag, "byp(R4)",   32'(byp_g), 32'(e.g.s == 4'd2 || e.g.s == 4'd3));
      chk(e.tag, "cc(R4)",    32'(cc_g),  32'(e.g.s == 4'd3));
      chk(e.tag, "mm(R8)",    32'(mm_g),  32'(e.g.mm));
      chk(e.tag, "rel(R11)",  32'(rel_g), 32'(e.g.s == 4'd8));
      chk(e.tag, "fstep(R3)", 32'(s_f),   32'(e.f.s));
      chk(e.tag, "fq(R10)",   32'(q_f),   32'((e.f.s == 4'd8) ? e.f.r : e.f.o));
      chk(e.tag, "fctl(R4)",  32'({byp_f, cc_f}), 32'd0);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "step", 32'(s_g), 0);
    chk("R1", "q", 32'(q_g), 0);
    chk("R1", "ctl", 32'({byp_g, cc_g}), 0);
    chk("R1", "flags", 32'({mm_g, rel_g}), 0);
    chk("R1", "fstep", 32'(s_f), 0);

    // A: plain transfer with enable low during capture (R5, R7, R2)
    drv("R7", 1'b1, 8'hA5, 1'b0, 1'b0);
    drv("R7", 1'b0, 8'h3C, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drv("R5", 1'b0, 8'h10 + 8'(i), 1'b1, 1'b0);
    drv("R2", 1'b0, 8'h44, 1'b1, 1'b0);
    drv("R6", 1'b0, 8'hFF, 1'b0, 1'b0);
    drv("R6", 1'b1, 8'h77, 1'b0, 1'b0);
    drv("R9", 1'b0, 8'h12, 1'b0, 1'b1);

    // B: user updates collide with the capture edge (R5, R6, R8)
    do_reset();
    drv("R5", 1'b1, 8'h5A, 1'b0, 1'b0);
    drv("R5", 1'b0, 8'h00, 1'b1, 1'b0);
    drv("R6", 1'b1, 8'h21, 1'b0, 1'b0);
    drv("R5", 1'b0, 8'h01, 1'b1, 1'b0);
    drv("R6", 1'b1, 8'h6E, 1'b0, 1'b0);
    drv("R5", 1'b0, 8'h02, 1'b1, 1'b0);
    drv("R5", 1'b1, 8'hC3, 1'b0, 1'b0);
    drv("R5", 1'b0, 8'h11, 1'b0, 1'b0);
    drv("R5", 1'b1, 8'h99, 1'b1, 1'b0);
    drv("R6", 1'b1, 8'hB2, 1'b0, 1'b0);
    drv("R6", 1'b0, 8'h0F, 1'b1, 1'b0);
    drv("R6", 1'b1, 8'hD4, 1'b1, 1'b0);
    drv("R8", 1'b1, 8'h2B, 1'b1, 1'b0);
    drv("R8", 1'b1, 8'h8C, 1'b0, 1'b0);
    drv("R8", 1'b0, 8'h01, 1'b0, 1'b0);
    drv("R7", 1'b1, 8'hE7, 1'b1, 1'b0);
    drv("R6", 1'b0, 8'h3E, 1'b0, 1'b0);
    drv("R6", 1'b1, 8'h4F, 1'b0, 1'b0);

    // D: abort paths (R9)
    do_reset();
    drv("R9", 1'b1, 8'h66, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) drv("R9", 1'b0, 8'h70 + 8'(i), 1'b1, 1'b0);
    drv("R9", 1'b1, 8'hE1, 1'b0, 1'b1);
    drv("R9", 1'b0, 8'h00, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) drv("R9", 1'b0, 8'h80 + 8'(i), 1'b1, 1'b0);
    drv("R9", 1'b1, 8'h5C, 1'b1, 1'b1);
    drv("R10", 1'b0, 8'h9D, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) drv("R8", 1'b0, 8'h30 + 8'(i), 1'b1, 1'b0);
    drv("R9", 1'b1, 8'hAB, 1'b0, 1'b1);
    drv("R9", 1'b0, 8'hCD, 1'b0, 1'b0);

    drv("R10", 1'b0, 8'h00, 1'b0, 1'b0);
    while (sb.size() > 0) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule